// File: doc/BRIEF.md
# Segment Table Address Translator

This block translates segmented virtual addresses into physical addresses. A request carries a segment number, a byte displacement and an access kind. The segment number selects one entry of a small on-chip table. Each entry holds a present flag, three permission bits, the segment size in bytes and the physical base of the segment.

If the request is legal, the physical address is the base plus the displacement. If it is not, the block reports exactly one of three faults: the segment is absent, the displacement lies outside the segment, or the permissions forbid this kind of access.

Table entries are loaded through a separate write port, which can update one entry per cycle. Each response appears one clock after its request. Software above the block handles the faults and fills the table.

Top module: `seg_xlate`

## Requirements
- R1: After reset, rsp_valid is 0, every fault output is 0, rsp_addr is 0 and every table entry is marked absent.
- R2: rsp_valid is 1 in the cycle after a cycle with req_valid high, and 0 in the cycle after a cycle with req_valid low.
- R3: A request that raises no fault returns rsp_addr = (base + displacement) modulo 2^24, with the displacement zero-extended.
- R4: A request whose entry is absent raises rsp_miss, whatever its displacement or kind.
- R5: On a present entry, a displacement greater than or equal to the stored size raises rsp_ovf. A size of 0 makes every displacement overflow. Overflow takes precedence over a permission fault.
- R6: On a present entry with the displacement in range, rsp_prot is raised when the kind is not permitted. The kinds are 0 read, 1 write, 2 execute and 3 reserved. Permission bit 0 allows read, bit 1 allows write and bit 2 allows execute. The reserved kind is never permitted.
- R7: At most one fault output is high in any cycle, and rsp_addr is 0 whenever a fault is raised.
- R8: A write replaces all fields of the addressed entry from the next cycle on. A lookup of that entry in the same cycle as the write uses the old contents.
- R9: While rsp_valid is 0, rsp_addr and all fault outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Load one table entry |
| wr_seg | input | 4 | Entry to load |
| wr_present | input | 1 | Present flag to store |
| wr_perm | input | 3 | Permission bits: [0] read, [1] write, [2] execute |
| wr_size | input | 17 | Segment size in bytes (0 to 65536) |
| wr_base | input | 24 | Physical base of the segment |
| req_valid | input | 1 | Translation request |
| req_seg | input | 4 | Segment number |
| req_disp | input | 16 | Byte displacement |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_addr | output | 24 | Physical address, 0 on fault |
| rsp_miss | output | 1 | Absent-segment fault |
| rsp_ovf | output | 1 | Displacement out of range |
| rsp_prot | output | 1 | Access kind not permitted |

## Verification
The assertions check the following on every cycle:
- the one-cycle response timing;
- that at most one fault is raised;
- that outputs stay quiet when no response is valid;
- that the address is zeroed on a fault;
- that a reserved access kind always faults.

The table contents cannot be seen at the ports, so the directed scenarios must show the rest:
- the address sums, including wraparound;
- the size boundary at equality and at zero;
- fault priority between overlapping causes;
- the permission decode;
- the old-contents result when an entry is written and looked up in the same cycle.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_W  = 4,
  parameter int DISP_W = 16,
  parameter int PA_W   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  wr_seg,
  input  logic              wr_present,
  input  logic [2:0]        wr_perm,
  input  logic [DISP_W:0]   wr_size,
  input  logic [PA_W-1:0]   wr_base,
  input  logic              req_valid,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [1:0]        req_kind,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_addr,
  output logic              rsp_miss,
  output logic              rsp_ovf,
  output logic              rsp_prot
);

  localparam int NSEG = 1 << SEG_W;
  localparam int PAD  = PA_W - DISP_W;

  logic [NSEG-1:0]   present_q;
  logic [2:0]        perm_q [NSEG];
  logic [DISP_W:0]   size_q [NSEG];
  logic [PA_W-1:0]   base_q [NSEG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) present_q <= '0;
    else if (wr_en) present_q[wr_seg] <= wr_present;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      perm_q[wr_seg] <= wr_perm;
      size_q[wr_seg] <= wr_size;
      base_q[wr_seg] <= wr_base;
    end
  end

  logic            miss, ovf, allowed;
  logic [2:0]      perm;
  logic [PA_W-1:0] sum;

  assign perm = perm_q[req_seg];
  assign miss = !present_q[req_seg];
  assign ovf  = {1'b0, req_disp} >= size_q[req_seg];
  assign sum  = base_q[req_seg] + {{PAD{1'b0}}, req_disp};

  always_comb begin
    case (req_kind)
      2'd0:    allowed = perm[0];
      2'd1:    allowed = perm[1];
      2'd2:    allowed = perm[2];
      default: allowed = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_ovf   <= 1'b0;
      rsp_prot  <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_miss  <= req_valid && miss;
      rsp_ovf   <= req_valid && !miss && ovf;
      rsp_prot  <= req_valid && !miss && !ovf && !allowed;
      rsp_addr  <= (req_valid && !miss && !ovf && allowed) ? sum : '0;
    end
  end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int PA_W = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [1:0]      req_kind,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_addr,
  input logic            rsp_miss,
  input logic            rsp_ovf,
  input logic            rsp_prot
);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r7_single_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_miss, rsp_ovf, rsp_prot}));

  a_r7_addr_zero_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_miss || rsp_ovf || rsp_prot) |-> rsp_addr == '0);

  a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_addr == '0 && !rsp_miss && !rsp_ovf && !rsp_prot));

  a_r6_reserved_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd3) |=> (rsp_miss || rsp_ovf || rsp_prot));

endmodule

bind seg_xlate seg_xlate_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_miss(rsp_miss),
  .rsp_ovf(rsp_ovf), .rsp_prot(rsp_prot)
);

// File: tb/tb_seg_xlate.sv
`timescale 1ns/1ps
module tb_seg_xlate;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [3:0]  wr_seg = 0;
  logic        wr_present = 0;
  logic [2:0]  wr_perm = 0;
  logic [16:0] wr_size = 0;
  logic [23:0] wr_base = 0;
  logic        req_valid = 0;
  logic [3:0]  req_seg = 0;
  logic [15:0] req_disp = 0;
  logic [1:0]  req_kind = 0;
  logic        rsp_valid, rsp_miss, rsp_ovf, rsp_prot;
  logic [23:0] rsp_addr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  seg_xlate dut (.*);

  localparam logic [2:0] OK = 3'b000, MISS = 3'b001, OVF = 3'b010, PROT = 3'b100;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic write_entry(logic [3:0] s, logic p, logic [2:0] pm, logic [16:0] sz, logic [23:0] b);
    @(negedge clk);
    wr_en = 1; wr_seg = s; wr_present = p; wr_perm = pm; wr_size = sz; wr_base = b;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic lookup(string tag, logic [3:0] s, logic [15:0] d, logic [1:0] k,
                        logic [2:0] exp_f, logic [23:0] exp_a);
    @(negedge clk);
    req_valid = 1; req_seg = s; req_disp = d; req_kind = k;
    @(negedge clk);
    req_valid = 0;
    check(tag, {4'd0, rsp_valid, rsp_prot, rsp_ovf, rsp_miss, rsp_addr},
               {4'd0, 1'b1, exp_f, exp_a});
  endtask

  task automatic t_reset;
    check("R1 reset outputs", {rsp_valid, rsp_miss, rsp_ovf, rsp_prot, rsp_addr}, 0);
    lookup("R1 entry absent after reset", 4'd0, 16'd0, 2'd0, MISS, 0);
    lookup("R1 last entry absent after reset", 4'd15, 16'd0, 2'd0, MISS, 0);
  endtask

  task automatic t_translate;
    write_entry(4'd3, 1, 3'b011, 17'h01000, 24'h100000);
    lookup("R3 read sum", 4'd3, 16'h0abc, 2'd0, OK, 24'h100abc);
    lookup("R3 write at zero", 4'd3, 16'h0000, 2'd1, OK, 24'h100000);
    lookup("R5 last byte in range", 4'd3, 16'h0fff, 2'd0, OK, 24'h100fff);
    @(negedge clk);
    check("R2 R9 idle after response", {rsp_valid, rsp_miss, rsp_ovf, rsp_prot, rsp_addr}, 0);
  endtask

  task automatic t_bounds;
    lookup("R5 disp equal size", 4'd3, 16'h1000, 2'd0, OVF, 0);
    lookup("R5 disp max", 4'd3, 16'hffff, 2'd1, OVF, 0);
    lookup("R5 overflow over protection", 4'd3, 16'h2000, 2'd2, OVF, 0);
    write_entry(4'd7, 1, 3'b111, 17'd0, 24'h000400);
    lookup("R5 zero size overflows", 4'd7, 16'd0, 2'd0, OVF, 0);
  endtask

  task automatic t_perm;
    lookup("R6 execute denied", 4'd3, 16'h0010, 2'd2, PROT, 0);
    lookup("R6 reserved kind denied", 4'd3, 16'h0010, 2'd3, PROT, 0);
    write_entry(4'd9, 1, 3'b100, 17'h00100, 24'h040000);
    lookup("R6 execute allowed", 4'd9, 16'h0020, 2'd2, OK, 24'h040020);
    lookup("R6 read denied", 4'd9, 16'h0020, 2'd0, PROT, 0);
    lookup("R6 write denied", 4'd9, 16'h0020, 2'd1, PROT, 0);
  endtask

  task automatic t_missing;
    write_entry(4'd5, 0, 3'b000, 17'h00000, 24'h000000);
    lookup("R4 absent beats overflow and protect", 4'd5, 16'h8000, 2'd3, MISS, 0);
  endtask

  task automatic t_wrap;
    write_entry(4'd15, 1, 3'b111, 17'h10000, 24'hffff00);
    lookup("R3 wrap small", 4'd15, 16'h0200, 2'd0, OK, 24'h000100);
    lookup("R3 R5 full size max disp", 4'd15, 16'hffff, 2'd1, OK, 24'h00feff);
  endtask

  task automatic t_overlap;
    @(negedge clk);
    wr_en = 1; wr_seg = 4'd3; wr_present = 1; wr_perm = 3'b001; wr_size = 17'h00100; wr_base = 24'h200000;
    req_valid = 1; req_seg = 4'd3; req_disp = 16'h0004; req_kind = 2'd1;
    @(negedge clk);
    wr_en = 0; req_valid = 0;
    check("R8 same cycle sees old entry", {rsp_valid, rsp_prot, rsp_ovf, rsp_miss, rsp_addr},
          {1'b1, OK, 24'h100004});
    lookup("R8 new base used", 4'd3, 16'h0004, 2'd0, OK, 24'h200004);
    lookup("R8 new perm used", 4'd3, 16'h0004, 2'd1, PROT, 0);
    lookup("R8 new size used", 4'd3, 16'h0100, 2'd0, OVF, 0);
    write_entry(4'd3, 0, 3'b111, 17'h10000, 24'h200000);
    lookup("R8 cleared present", 4'd3, 16'h0004, 2'd0, MISS, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_translate;
    t_bounds;
    t_perm;
    t_missing;
    t_wrap;
    t_overlap;
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule